// File: doc/BRIEF.md
# PWM Time Base (Beat Divider and Phase Counter)

This block produces the common time reference that every channel of a multi-channel pulse-width modulator compares against. A programmable divider turns the input clock into beats, one beat every (div+1) input clocks. A phase counter advances by one step on each beat. It wraps to zero after 2^(resn+1) beats, and that span of beats is one PWM cycle. The phase is presented as a 16-bit fraction of a PWM cycle, so channel comparators can compare duty and delay values against it without rescaling. Only the top (resn+1) bits of the phase ever change.

A one-clock strobe marks the start of each PWM cycle. The strobe fires when the phase wraps to zero, and also on the first beat after the counter is switched on. Dropping the enable stops the counter and returns the phase to zero. Rewriting the divider value restarts the current beat.

Top module: `pwm_timebase`

## Requirements
- R1: While and after reset with the enable low, `phase_o` is 0 and `cycle_start_o` is 0.
- R2: With the enable high and `div_i` = N held constant, the phase advances on the clock edges numbered N, 2N+1, 3N+2, … and on no others. The edges are counted from 0 at the first edge that samples the enable high.
- R3: On each beat the phase increases by 2^(15-resn), modulo 2^16. For example, resn 15 gives a step of 1 and resn 3 gives a step of 0x1000.
- R4: After 2^(resn+1) beats the phase returns to 0. `cycle_start_o` is high for the one clock in which the wrapped phase 0 is shown.
- R5: `cycle_start_o` is also high for one clock after the first beat following a rise of the enable, while `phase_o` shows one step. At no other time is it high.
- R6: One clock after an edge that samples the enable low, `phase_o` is 0 and `cycle_start_o` is 0. Both stay there while the enable remains low.
- R7: A change of `div_i` while running keeps the phase and restarts the divider. The next beat comes N+2 edges after the change edge, counting the change edge as the first, where N is the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter enable; low stops and clears the phase |
| div_i | input | 27 | Beat length minus one, in input clocks |
| resn_i | input | 4 | Logarithmic phase resolution (resn+1 significant bits) |
| phase_o | output | 16 | Fractional phase of the current PWM cycle |
| cycle_start_o | output | 1 | One-clock strobe at the start of a PWM cycle |

## Verification
The hardest case to reach is a divider rewrite in the middle of a beat. The restart has to be told apart both from a divider that carries on counting and from one that merely loads the new limit. The bench lets two beats pass with a divide value of 3. It then changes the value to 1 at a known edge and samples the phase two and three edges later. Only a true restart gives an unchanged phase at the first sample and an advanced phase at the second. A coarse resolution of 0 with no division is also driven, so that the first-beat strobe and the wrap strobe fall on consecutive clocks.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  localparam int PHASE_W = 16;
  localparam int RESN_W  = 4;

  // Phase increment per beat for a given logarithmic resolution
  function automatic logic [PHASE_W-1:0] phase_step(input logic [RESN_W-1:0] resn);
    int r;
    r = int'(resn);
    if (r > PHASE_W - 1) r = PHASE_W - 1;
    return {{(PHASE_W-1){1'b0}}, 1'b1} << (PHASE_W - 1 - r);
  endfunction
endpackage

// File: rtl/pwm_beat_div.sv
module pwm_beat_div #(
  parameter int DIV_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             beat_o,
  output logic             div_chg_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             restart;

  assign div_chg_o = (div_i != div_q);
  assign restart   = !en_i || div_chg_o;
  assign beat_o    = !restart && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      div_q <= div_i;
      if (restart || beat_o) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  div_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !div_chg_o) |-> (cnt_q <= div_i));
endmodule

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr
  import pwm_timebase_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               beat_i,
  input  logic               hold_i,
  input  logic [RESN_W-1:0]  resn_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               start_o
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_nxt;
  logic [PHASE_W-1:0] step;
  logic               wrap;
  logic               armed_q;
  logic               start_q;

  assign step      = phase_step(resn_i);
  assign phase_nxt = phase_q + step;
  assign wrap      = (phase_nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      armed_q <= 1'b1;
      start_q <= 1'b0;
    end else if (!en_i) begin
      phase_q <= '0;
      armed_q <= 1'b1;
      start_q <= 1'b0;
    end else begin
      start_q <= beat_i && (armed_q || wrap);
      if (beat_i) begin
        phase_q <= phase_nxt;
        armed_q <= 1'b0;
      end
    end
  end

  assign phase_o = phase_q;
  assign start_o = start_q;

  // R6
  off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase_q == '0 && !start_q));
  // R4
  start_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (phase_q == '0 || phase_q == step));
  // R7
  chg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hold_i) |=> $stable(phase_q));
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !beat_i) |=> $stable(phase_q));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int DIV_W = 27
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_en_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [RESN_W-1:0]  resn_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               cycle_start_o
);
  logic beat;
  logic div_chg;

  pwm_beat_div #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cnt_en_i),
    .div_i     (div_i),
    .beat_o    (beat),
    .div_chg_o (div_chg)
  );

  pwm_phase_ctr u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cnt_en_i),
    .beat_i  (beat),
    .hold_i  (div_chg),
    .resn_i  (resn_i),
    .phase_o (phase_o),
    .start_o (cycle_start_o)
  );

  // R5
  start_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_o |-> $past(cnt_en_i));
endmodule

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [26:0] div = '0;
  logic [3:0]  resn = '0;
  logic [15:0] phase;
  logic        strobe;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwm_timebase u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .div_i(div),
    .resn_i(resn), .phase_o(phase), .cycle_start_o(strobe)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_phase(int beats, int r);
    return (beats << (15 - r)) & 16'hFFFF;
  endfunction

  task automatic idle_setup(int n, int r);
    @(negedge clk); en = 1'b0;
    @(negedge clk); div = 27'(n); resn = 4'(r);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Run from enable for k edges and check closed-form phase and strobe
  task automatic run_check(int n, int r, int kmax, string tag);
    idle_setup(n, r);
    en = 1'b1;
    for (int k = 1; k <= kmax; k++) begin
      int beats;
      int ph;
      int st;
      @(negedge clk);
      beats = k / (n + 1);
      ph = exp_phase(beats, r);
      st = ((k % (n + 1)) == 0 && (beats == 1 || ph == 0)) ? 1 : 0;
      check(tag, "phase", int'(phase), ph);
      check(tag, "strobe", int'(strobe), st);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "phase in reset", int'(phase), 0);
    check("R1", "strobe in reset", int'(strobe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "phase after reset", int'(phase), 0);
    check("R1", "strobe after reset", int'(strobe), 0);
  endtask

  task automatic t_disable();
    run_check(1, 4, 10, "R6");
    en = 1'b0;
    @(negedge clk);
    check("R6", "phase after disable", int'(phase), 0);
    check("R6", "strobe after disable", int'(strobe), 0);
    repeat (6) @(negedge clk);
    check("R6", "phase held off", int'(phase), 0);
    check("R6", "strobe held off", int'(strobe), 0);
    // re-enable: first beat strobes again
    en = 1'b1;
    @(negedge clk);
    check("R5", "no beat yet", int'(phase), 0);
    @(negedge clk);
    check("R5", "first beat phase", int'(phase), 16'h0800);
    check("R5", "first beat strobe", int'(strobe), 1);
    @(negedge clk);
    check("R5", "strobe one clock", int'(strobe), 0);
  endtask

  task automatic t_divchg();
    run_check(3, 3, 8, "R7");
    div = 27'd1;
    @(negedge clk);
    check("R7", "phase at change edge", int'(phase), 16'h2000);
    @(negedge clk);
    check("R7", "phase one edge after change", int'(phase), 16'h2000);
    @(negedge clk);
    check("R7", "beat after restart", int'(phase), 16'h3000);
    @(negedge clk);
    check("R7", "no beat between", int'(phase), 16'h3000);
    @(negedge clk);
    check("R7", "next beat new period", int'(phase), 16'h4000);
  endtask

  initial begin
    t_reset();
    run_check(2, 3, 60, "R2");
    run_check(1, 15, 20, "R3");
    run_check(0, 0, 8, "R4");
    run_check(3, 1, 40, "R5");
    t_disable();
    t_divchg();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule